// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage register that takes a whole byte at once and sends it out one bit at a time. While the load control is high, the stages take the parallel word at once, without waiting for a clock. Once load drops, each rising clock edge moves every stage one place toward the last stage. The last stage is the only one visible outside the block, on a true output and a complemented output.

A serial input feeds the first stage as the word moves along. Wiring one register's serial output to the next register's serial input therefore chains several registers into a longer one. A hold input stops shifting without disturbing the stored word. It suits byte-to-bitstream conversion, where a parallel source is captured once and then sent out over a single wire.

Top module: `piso_shifter`

## Requirements
- R1: While `load` is 1, the stages take `par_d` without waiting for a clock, and `ser_q` shows `par_d[7]` within the same cycle.
- R2: `load` takes priority over both the clock and `hold`: while `load` is 1, clock edges leave the state equal to `par_d` whatever `hold` is.
- R3: With `load` at 0 and `hold` at 0, each rising edge of `clk` moves stage n into stage n+1, for n from 0 to 6.
- R4: After a load, `ser_q` presents `par_d[7]` first and then, after each shift edge, `par_d[6]` and so on down to `par_d[0]` after seven shifts. Bit 7 leaves first.
- R5: On each shift edge `ser_d` enters stage 0, and it appears on `ser_q` eight shift edges later.
- R6: With `load` at 0 and `hold` at 1, clock edges leave every stage unchanged, so `ser_q` and everything shifted out later stay the same as with no edge.
- R7: `ser_q_n` is always the inverse of `ser_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| load | input | 1 | Level-sensitive parallel load, active high, asynchronous |
| hold | input | 1 | Clock inhibit, active high |
| ser_d | input | 1 | Serial bit entering the first stage |
| par_d | input | 8 | Parallel word; bit 7 leaves first |
| ser_q | output | 1 | Last stage |
| ser_q_n | output | 1 | Complement of the last stage |

## Verification
A load shows on `ser_q` within the same cycle: there is no register between `par_d` and the output while `load` is high. The bench checks this 1 ns after it drives the load, before any clock edge. A shift or a held edge shows its result one edge later. The bench drives all inputs on the falling edge, updates its model of the stages at the rising edge, and compares `ser_q` and `ser_q_n` at the next falling edge. Serial bits therefore come out in order: P7 right after a load, then one bit per shift edge, and `ser_d` bits eight shift edges after they enter.

// File: rtl/piso_shifter.sv
module piso_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             load,
  input  logic             hold,
  input  logic             ser_d,
  input  logic [WIDTH-1:0] par_d,
  output logic             ser_q,
  output logic             ser_q_n
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] stages;

  always_ff @(posedge clk or posedge load) begin
    if (load)
      stages <= par_d;
    else if (!hold)
      stages <= {stages[LAST-1:0], ser_d};
  end

  assign ser_q   = load ? par_d[LAST] : stages[LAST];
  assign ser_q_n = ~ser_q;

  logic armed = 1'b0;
  always_ff @(posedge clk or posedge load)
    if (load) armed <= 1'b1;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!armed)
    (load && $past(load) && $stable(par_d)) |-> stages == par_d);  // R2

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!armed)
    (!load && !$past(load) && !$past(hold)) |->
      (stages[LAST:1] == $past(stages[LAST-1:0]) && stages[0] == $past(ser_d)));  // R3

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!armed)
    (!load && !$past(load) && $past(hold)) |-> $stable(stages));  // R6

  AST_OUT_ORDER: assert property (@(posedge clk) disable iff (!armed)
    (!load && !$past(load) && !$past(hold)) |-> ser_q == $past(stages[LAST-1]));  // R4

  always_comb
    if (armed) AST_COMPLEMENT: assert (ser_q_n == !ser_q);  // R7

endmodule

// File: tb/piso_shifter_tb.sv
module piso_shifter_tb;
  logic       clk = 1'b0;
  logic       load = 1'b0;
  logic       hold = 1'b0;
  logic       ser_d = 1'b0;
  logic [7:0] par_d = 8'h00;
  logic       ser_q, ser_q_n;

  int checks = 0;
  int fails = 0;
  logic [7:0] model = 8'h00;

  always #2.5 clk = ~clk;

  piso_shifter u_dut (
    .clk(clk), .load(load), .hold(hold), .ser_d(ser_d),
    .par_d(par_d), .ser_q(ser_q), .ser_q_n(ser_q_n)
  );

  function automatic logic [7:0] next_state(logic [7:0] cur, logic l, logic h,
                                            logic s, logic [7:0] p);
    if (l) return p;
    if (h) return cur;
    return {cur[6:0], s};
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic l, input logic h, input logic s,
                      input logic [7:0] p, input string tag);
    load = l; hold = h; ser_d = s; par_d = p;
    if (l) begin
      model = p;
      #1;
      check(ser_q, p[7], "R1 transparent load");
    end
    @(posedge clk);
    model = next_state(model, l, h, s, p);
    @(negedge clk);
    check(ser_q, model[7], tag);
    check(ser_q_n, ~model[7], "R7 complement");
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1207));
    @(negedge clk);
    step(1'b1, 1'b0, 1'b0, 8'h00, "R1 reset load");
    step(1'b1, 1'b0, 1'b0, 8'h00, "R1 reset load");
    check(ser_q, 1'b0, "R1 reset out");

    // directed: bit order of a fixed word
    step(1'b1, 1'b0, 1'b0, 8'b1011_0010, "R1 load");
    step(1'b0, 1'b0, 1'b1, 8'h00, "R4 order");
    for (int k = 0; k < 7; k++) step(1'b0, 1'b0, 1'b1, 8'h00, "R4 order");
    for (int k = 0; k < 8; k++) step(1'b0, 1'b0, 1'b0, 8'h00, "R5 serial in");

    // directed: load beats hold, and transparency to a changing word
    step(1'b1, 1'b1, 1'b0, 8'h80, "R2 load over hold");
    step(1'b1, 1'b1, 1'b1, 8'h7f, "R2 load over hold");
    step(1'b1, 1'b0, 1'b1, 8'hc3, "R2 load over clock");
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 1'b1, 8'h00, "R6 hold freeze");
    for (int k = 0; k < 8; k++) step(1'b0, 1'b0, 1'b0, 8'hff, "R3 shift");

    // random words, serial bits and hold bursts
    for (int w = 0; w < 40; w++) begin
      logic [7:0] word;
      word = 8'($urandom);
      step(1'b1, 1'($urandom), 1'($urandom), word, "R2 load");
      for (int k = 0; k < 16; k++) begin
        logic h;
        h = ($urandom % 4) == 0;
        step(1'b0, h, 1'($urandom), 8'($urandom),
             h ? "R6 hold" : (k < 8 ? "R4 order" : "R5 chain"));
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule